// File: doc/BRIEF.md
# Universal Shift Register with Shared Bidirectional Bus

This block holds one word of `WIDTH` bits (eight by default). A two-bit mode input sets what the register does on each rising clock edge. It can keep its contents, shift toward the high end, shift toward the low end, or capture a word from the parallel bus. The parallel bus is shared between reading and writing. The register drives the bus only when both active-low output enables are low and load mode is not selected. As a result, an external source can present data for a load without contention.

Two serial taps carry the lowest and the highest bit at all times, whether the bus is driven or not. Several instances can be chained through these taps into a longer word. The tri-state bus is modelled as three signals:

- a sampled input word;
- a drive-data word that always carries the register contents;
- a drive-enable flag.

The pad or bus resolver outside the block combines these three signals.

An active-low reset clears the register at once, without waiting for the clock. It overrides the mode input. All other state changes happen on the rising clock edge.

Top module: `usr_bus_shift`

## Requirements
- R1: With `mode` = 2'b00 (hold) the register keeps its contents across the edge.
- R2: With `mode` = 2'b01 (shift up) the register becomes {q[WIDTH-2:0], `ser_up_in`}: the serial input enters bit 0 and bit i moves to bit i+1.
- R3: With `mode` = 2'b10 (shift down) the register becomes {`ser_dn_in`, q[WIDTH-1:1]}: the serial input enters bit WIDTH-1 and bit i moves to bit i-1.
- R4: With `mode` = 2'b11 (load) the register takes `bus_in` on the edge.
- R5: While `rst_n` is low the register is zero. Reset takes effect without a clock edge and overrides every mode.
- R6: `bus_oe` is 0 whenever `oe_a_n` or `oe_b_n` is 1.
- R7: `bus_oe` is 0 whenever `mode` = 2'b11, so a load never sees the block driving the bus. `bus_oe` is 1 when both enables are 0 and the mode is not load. `bus_out` always carries the register contents.
- R8: Hold, shift and load work unchanged while the bus is released. Only `bus_oe` depends on the enables.
- R9: `tap_lo` equals bit 0 and `tap_hi` equals bit WIDTH-1 at all times, independent of the enables and of the mode.
- R10: Two instances chained through their taps (low word's `tap_hi` to high word's `ser_up_in`, high word's `tap_lo` to low word's `ser_dn_in`) shift as one 2·WIDTH-bit register in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| ser_up_in | input | 1 | Serial bit entering bit 0 on shift up |
| ser_dn_in | input | 1 | Serial bit entering bit WIDTH-1 on shift down |
| bus_in | input | WIDTH | Value sampled from the shared bus |
| bus_out | output | WIDTH | Value driven onto the bus (register contents) |
| bus_oe | output | 1 | Bus drive enable |
| tap_lo | output | 1 | Serial tap, bit 0 |
| tap_hi | output | 1 | Serial tap, bit WIDTH-1 |

## Verification
The register contents and both taps change one rising edge after the mode, serial and bus inputs are applied. The bench therefore drives each input set on a falling edge and compares against its model on the next falling edge, after exactly one rising edge. `bus_oe` is combinational on the enables and the mode. It is checked one time unit after new inputs are driven, before any clock edge. Reset is checked one time unit after `rst_n` falls in mid-cycle, away from any edge, to show that it acts without the clock.

// File: rtl/usr_pkg.sv
// Shared definitions for the universal shift register.
// Assumes the two-bit mode code listed below; neighbours decode it the same way.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_UP    = 2'b01,
        MODE_DOWN  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_t;
endpackage

// File: rtl/usr_bus_ctl.sv
// Bus drive control: decides when the register may drive the shared bus.
// Assumes the enables are active low; load mode always releases the bus.
module usr_bus_ctl
    import usr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output logic       drive_en
);
    // Drive only when both enables are asserted and no load is pending.
    always_comb begin
        drive_en = !oe_a_n && !oe_b_n && (usr_mode_t'(mode) != MODE_LOAD);
    end
endmodule

// File: rtl/usr_next_state.sv
// Next-state selector: one multiplexer per bit, chosen by the mode code.
// Assumes WIDTH >= 2; bit 0 and bit WIDTH-1 take the serial inputs.
module usr_next_state
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    output logic [WIDTH-1:0] nxt
);
    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_lo_edge
            assign from_below = ser_up_in;
        end else begin : g_lo_mid
            assign from_below = cur[i-1];
        end

        if (i == TOP) begin : g_hi_edge
            assign from_above = ser_dn_in;
        end else begin : g_hi_mid
            assign from_above = cur[i+1];
        end

        // Pick this bit's next value from the mode.
        always_comb begin
            case (usr_mode_t'(mode))
                MODE_UP:   nxt[i] = from_below;
                MODE_DOWN: nxt[i] = from_above;
                MODE_LOAD: nxt[i] = par_in[i];
                default:   nxt[i] = cur[i];
            endcase
        end
    end
endmodule

// File: rtl/usr_bus_shift.sv
// Universal shift register on a shared bus: hold, shift up, shift down, load.
// Assumes an external resolver merges bus_out/bus_oe with other drivers into bus_in.
// Reset is asynchronous and active low, as the block's behaviour requires.
module usr_bus_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             tap_lo,
    output logic             tap_hi
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] q_nxt;

    usr_next_state #(.WIDTH(WIDTH)) u_next (
        .mode      (mode),
        .cur       (q),
        .par_in    (bus_in),
        .ser_up_in (ser_up_in),
        .ser_dn_in (ser_dn_in),
        .nxt       (q_nxt)
    );

    usr_bus_ctl u_ctl (
        .mode     (mode),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .drive_en (bus_oe)
    );

    // Register update: clear at once on reset, else take the selected next value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

    assign bus_out = q;
    assign tap_lo  = q[0];
    assign tap_hi  = q[TOP];
endmodule

// File: rtl/usr_bus_shift_chk.sv
// Property checker for usr_bus_shift, attached by bind; observes ports only.
module usr_bus_shift_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             ser_up_in,
    input logic             ser_dn_in,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic             tap_lo,
    input logic             tap_hi
);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (bus_out == $past(bus_out)));

    assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_up_in)}));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (bus_out == {$past(ser_dn_in), $past(bus_out[WIDTH-1:1])}));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (bus_out == $past(bus_in)));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !bus_oe);

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> !bus_oe);

    assert_taps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_lo == bus_out[0]) && (tap_hi == bus_out[WIDTH-1]));

    // Reset clears the word while held low (R5).
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            assert_reset_clear_R5: assert (bus_out == '0);
        end
    end
endmodule

bind usr_bus_shift usr_bus_shift_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_usr_bus_shift.sv
module tb_usr_bus_shift;
    localparam int W      = 8;
    localparam int W2     = 2 * W;
    localparam int PERIOD = 10;
    localparam int STEPS  = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic ser_up = 1'b0, ser_dn = 1'b0;
    logic [W-1:0] data_lo = '0, data_hi = '0;

    logic [W-1:0] out_lo, out_hi;
    logic oe_lo, oe_hi;
    logic tlo_lo, thi_lo, tlo_hi, thi_hi;

    int checks = 0;
    int fails  = 0;
    logic [W2-1:0] model = '0;

    always #(PERIOD/2) clk = ~clk;

    // Low word instance: serial up from bench, serial down from high word.
    usr_bus_shift #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_up_in(ser_up), .ser_dn_in(tlo_hi), .bus_in(data_lo),
        .bus_out(out_lo), .bus_oe(oe_lo), .tap_lo(tlo_lo), .tap_hi(thi_lo)
    );

    // High word instance: serial up from low word, serial down from bench.
    usr_bus_shift #(.WIDTH(W)) dut_hi (
        .clk(clk), .rst_n(rst_n), .mode(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_up_in(thi_lo), .ser_dn_in(ser_dn), .bus_in(data_hi),
        .bus_out(out_hi), .bus_oe(oe_hi), .tap_lo(tlo_hi), .tap_hi(thi_hi)
    );

    function automatic logic [W2-1:0] next_model(logic [W2-1:0] cur, logic [1:0] m,
                                                  logic su, logic sd, logic [W2-1:0] par);
        case (m)
            2'b01:   return {cur[W2-2:0], su};
            2'b10:   return {sd, cur[W2-1:1]};
            2'b11:   return par;
            default: return cur;
        endcase
    endfunction

    function automatic logic exp_oe(logic a, logic b, logic [1:0] m);
        return !a && !b && (m != 2'b11);
    endfunction

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b01:   return "R2/R10";
            2'b10:   return "R3/R10";
            2'b11:   return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string req, logic [W2-1:0] act, logic [W2-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one input set at a falling edge, check drive enable, then state after one rising edge.
    task automatic step(logic [1:0] m, logic a, logic b, logic su, logic sd, logic [W2-1:0] par);
        logic [W2-1:0] exp_state;
        mode = m; oe_a_n = a; oe_b_n = b; ser_up = su; ser_dn = sd;
        {data_hi, data_lo} = par;
        #1;
        if (a || b) check("R6", {oe_hi, oe_lo}, {2'b00});
        else if (m == 2'b11) check("R7 contention", {oe_hi, oe_lo}, {2'b00});
        else check("R7", {oe_hi, oe_lo}, {2{exp_oe(a, b, m)}});
        exp_state = next_model(model, m, su, sd, par);
        @(negedge clk);
        model = exp_state;
        if (a || b) check({mode_tag(m), " R8 released"}, {out_hi, out_lo}, model);
        else        check(mode_tag(m), {out_hi, out_lo}, model);
        check("R9", {thi_hi, tlo_hi, thi_lo, tlo_lo},
              {model[W2-1], model[W], model[W-1], model[0]});
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_2024));
        @(negedge clk);
        check("R5 reset state", {out_hi, out_lo}, '0);
        rst_n = 1'b1;

        // Directed: load a pattern, drive it, walk it up and down across the chain.
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3);
        step(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF);
        for (int i = 0; i < W2; i++) step(2'b01, 1'b0, 1'b0, i[0], 1'b0, '0);
        for (int i = 0; i < W2; i++) step(2'b10, 1'b1, 1'b0, 1'b0, ~i[1], '0);
        step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'h8001);
        step(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, '0);
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, '0);

        // Random mix of modes, enables, serial bits and bus words.
        for (int n = 0; n < STEPS; n++) begin
            step(2'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                 1'($urandom), 1'($urandom), 16'($urandom));
        end

        // Asynchronous reset in mid-cycle while a load is requested.
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7E7E);
        mode = 2'b11; {data_hi, data_lo} = 16'hFFFF;
        @(posedge clk); #2;
        rst_n = 1'b0;
        #1;
        check("R5 async clear", {out_hi, out_lo}, '0);
        @(posedge clk); #1;
        check("R5 overrides load", {out_hi, out_lo}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        step(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, '0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule